// File: doc/BRIEF.md
# Receive Line Status with Error-Tagged FIFO

This block is the receive-side status path of one serial channel. Each character that the receive shift logic completes arrives with its own parity, framing and break tags. The character and its tags are stored together in a queue of up to 32 entries. The host pops the queue with a data read strobe. An 8-bit line status word reports the head character's tags, an overrun event, a global "some stored character is bad" flag and two transmit-side occupancy flags. A line-status interrupt request is raised from the same information when the host enables it.

Error tags travel with their character. Bits 2 to 4 therefore always describe the character the host is about to read, and a running tally of tagged entries drives bit 7. A break, meaning the receive line held low for a whole frame, is stored once as a zero byte with the break tag set. Further completions are then refused until the line goes high again. A mode input shrinks the queue to a single holding slot.

Top module: `uart_rx_lsr`

## Requirements
- R1: lsr[0] is 1 whenever at least one character is stored and 0 when none is. `rd_data` shows the oldest stored byte, or 0 when the queue is empty.
- R2: A completed character that arrives while the queue is full, with no data read in the same cycle, sets lsr[1]. That character is discarded and the stored characters keep their values and order.
- R3: A character that completes while the queue is full, in the same cycle as a data read, is stored and does not set lsr[1].
- R4: lsr[2] (parity), lsr[3] (framing) and lsr[4] (break) equal the tags of the oldest stored entry, or 0 when the queue is empty. They change only when the head entry is popped, or when a character enters an empty queue.
- R5: A completion flagged as break stores one entry with data 0x00 and the break tag only. All later completions are ignored until `rx_line` is sampled high.
- R6: lsr[5] is 1 exactly when `tx_level` is zero.
- R7: lsr[6] is 1 exactly when `tx_level` is zero and `tx_shift_busy` is 0.
- R8: lsr[7] is 1 while any stored entry carries a parity, framing or break tag. It returns to 0 once the last such entry has been popped.
- R9: `lsi_irq` is 1 exactly when `lsi_en` is 1 and any of lsr[1], lsr[2], lsr[3] or lsr[4] is 1.
- R10: A status read (`host_rd_lsr`) clears lsr[1] on the next cycle. If a new overrun occurs in the same cycle, lsr[1] stays 1.
- R11: When `fifo_mode` is 0, the capacity is one character, so a second character completed before a data read causes an overrun.
- R12: After reset the queue is empty and lsr[0], lsr[1], lsr[2], lsr[3], lsr[4] and lsr[7] are 0, so with the transmitter idle the word reads 0x60.
- R13: Characters leave the queue in arrival order, and the queue holds `DEPTH` (32) entries in queue mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 = 32-entry queue, 0 = single holding slot |
| rx_done | input | 1 | Receive shift logic completed a character this cycle |
| rx_data | input | 8 | Completed character |
| rx_perr | input | 1 | Parity tag of the completed character |
| rx_ferr | input | 1 | Framing tag of the completed character |
| rx_brk | input | 1 | Completed frame was a break |
| rx_line | input | 1 | Current receive line level (1 = idle) |
| host_rd_data | input | 1 | Host reads and pops the head character |
| host_rd_lsr | input | 1 | Host reads the status word |
| lsi_en | input | 1 | Line-status interrupt enable |
| tx_level | input | 6 | Transmit queue / holding occupancy |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rd_data | output | 8 | Head character |
| lsr | output | 8 | Line status word |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
The bench fills the queue to exactly 32 entries and then presents a 33rd character. A design that wrote it anyway would corrupt the oldest byte, and one that refused it without a flag would lose lsr[1]. A character arriving on a full queue in the same cycle as a pop must be stored; an off-by-one full test would raise a false overrun or drop the byte. A tagged character queued behind a clean one must leave bits 2 to 4 clear until it reaches the head, which catches designs that expose the tail tags. A break followed by more frames on a low line must produce exactly one entry, and a status read that coincides with a fresh overrun must leave lsr[1] set.

// File: rtl/lsr_pkg.sv
// Shared types for the receive line status block.
// Assumes: one stored entry is a byte plus three tag bits.
package lsr_pkg;

    localparam int DATA_W = 8;

    // One queued character with its error tags (11 bits).
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/lsr_rx_fifo.sv
// Circular queue of tagged receive characters.
// Assumes: DEPTH is a power of two; push is only asserted when room exists
// (the caller gates it); single_mode is static while data is held.
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      single_mode,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic [LW-1:0] level
);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            do_pop;

    assign do_pop = pop && !empty;

    // Write the incoming entry into storage.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            case ({push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    // Occupancy flags and head view.
    always_comb begin
        empty = (level == '0);
        full  = single_mode ? (level != '0) : (level == LW'(DEPTH));
        head  = empty ? '0 : mem[rd_ptr];
    end

endmodule

// File: rtl/lsr_err_tally.sv
// Counts queued entries that carry any error tag.
// Assumes: inc/dec already qualified by an actual push/pop.
module lsr_err_tally #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic          any_err,
    output logic [CW-1:0] tally
);

    // Up/down count; a simultaneous inc and dec leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   tally <= tally + CW'(1);
                2'b01:   tally <= tally - CW'(1);
                default: tally <= tally;
            endcase
        end
    end

    // Any tagged entry present.
    assign any_err = (tally != '0);

endmodule

// File: rtl/lsr_break_gate.sv
// Collapses a break event into one accepted completion and blocks
// further completions until the receive line is seen idle high.
// Assumes: rx_line is already synchronised to clk.
module lsr_break_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_done,
    input  logic rx_brk,
    input  logic rx_line,
    output logic accept,
    output logic locked
);

    // A completion passes only when no break is pending.
    assign accept = rx_done && !locked;

    // Arm on an accepted break, release on idle line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (accept && rx_brk) begin
            locked <= 1'b1;
        end else if (rx_line) begin
            locked <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_lsr.sv
// Receive line status block: tagged receive queue, overrun flag,
// break collapsing, global error flag, transmit flags and interrupt.
// Assumes: fifo_mode only changes while the queue is empty.
module uart_rx_lsr
    import lsr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TXW   = 6,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fifo_mode,
    input  logic           rx_done,
    input  logic [7:0]     rx_data,
    input  logic           rx_perr,
    input  logic           rx_ferr,
    input  logic           rx_brk,
    input  logic           rx_line,
    input  logic           host_rd_data,
    input  logic           host_rd_lsr,
    input  logic           lsi_en,
    input  logic [TXW-1:0] tx_level,
    input  logic           tx_shift_busy,
    output logic [7:0]     rd_data,
    output logic [7:0]     lsr,
    output logic           lsi_irq
);

    logic          accept;
    logic          brk_lock;
    logic          q_empty;
    logic          q_full;
    logic [LW-1:0] q_level;
    logic          pop;
    logic          room;
    logic          push;
    logic          ovr_evt;
    logic          ovr_q;
    logic          any_err;
    logic [LW-1:0] err_tally;
    rx_entry_t     new_entry;
    rx_entry_t     head;

    lsr_break_gate u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_done (rx_done),
        .rx_brk  (rx_brk),
        .rx_line (rx_line),
        .accept  (accept),
        .locked  (brk_lock)
    );

    // Build the entry to store: a break stores a zero byte, break tag only.
    always_comb begin
        if (rx_brk) begin
            new_entry = '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
        end else begin
            new_entry = '{brk: 1'b0, ferr: rx_ferr, perr: rx_perr, data: rx_data};
        end
    end

    // Push is allowed when space exists or a pop frees a slot this cycle.
    always_comb begin
        pop     = host_rd_data && !q_empty;
        room    = !q_full || pop;
        push    = accept && room;
        ovr_evt = accept && !room;
    end

    lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_mode (!fifo_mode),
        .push        (push),
        .wr_entry    (new_entry),
        .pop         (pop),
        .head        (head),
        .empty       (q_empty),
        .full        (q_full),
        .level       (q_level)
    );

    lsr_err_tally #(.CW(LW)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (push && (new_entry.brk || new_entry.ferr || new_entry.perr)),
        .dec     (pop && (head.brk || head.ferr || head.perr)),
        .any_err (any_err),
        .tally   (err_tally)
    );

    // Overrun flag: set by a dropped character, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (ovr_evt) begin
            ovr_q <= 1'b1;
        end else if (host_rd_lsr) begin
            ovr_q <= 1'b0;
        end
    end

    // Assemble the status word, head data and interrupt request.
    always_comb begin
        lsr[0]  = !q_empty;
        lsr[1]  = ovr_q;
        lsr[2]  = head.perr;
        lsr[3]  = head.ferr;
        lsr[4]  = head.brk;
        lsr[5]  = (tx_level == '0);
        lsr[6]  = (tx_level == '0) && !tx_shift_busy;
        lsr[7]  = any_err;
        rd_data = head.data;
        lsi_irq = lsi_en && (ovr_q || head.perr || head.ferr || head.brk);
    end

endmodule

// File: rtl/lsr_checks.sv
// Temporal checks on the receive line status block, attached by bind.
module lsr_checks #(
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_done,
    input logic          host_rd_data,
    input logic          host_rd_lsr,
    input logic          lsi_en,
    input logic [7:0]    lsr,
    input logic          lsi_irq,
    input logic          brk_lock,
    input logic          q_full,
    input logic [LW-1:0] q_level
);

    // R1: popping the last entry with nothing arriving empties the queue
    a_r1_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data && (q_level == LW'(1)) && !rx_done |=> !lsr[0]);

    // R2: a character on a full queue without a pop flags overrun and is dropped
    a_r2_overrun_drops: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && rx_done && !brk_lock && !host_rd_data |=> lsr[1] && $stable(q_level));

    // R4: head tags hold while the queue is non-empty and not popped
    a_r4_head_tags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[0] && !host_rd_data |=> $stable(lsr[4:2]));

    // R5: completions during a pending break are ignored
    a_r5_break_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        brk_lock && rx_done && !host_rd_data |=> $stable(q_level));

    // R7: idle transmitter implies empty transmit queue
    a_r7_idle_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    // R8: errors recorded only while entries are stored
    a_r8_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> lsr[0]);

    // R9: interrupt gated by enable
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !lsi_en |-> !lsi_irq);

    // R9: overrun raises the interrupt at once when enabled
    a_r9_irq_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        lsi_en && lsr[1] |-> lsi_irq);

    // R10: a status read with no new arrival clears overrun
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_lsr && !rx_done |=> !lsr[1]);

endmodule

bind uart_rx_lsr lsr_checks #(.LW(LW)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_done      (rx_done),
    .host_rd_data (host_rd_data),
    .host_rd_lsr  (host_rd_lsr),
    .lsi_en       (lsi_en),
    .lsr          (lsr),
    .lsi_irq      (lsi_irq),
    .brk_lock     (brk_lock),
    .q_full       (q_full),
    .q_level      (q_level)
);

// File: tb/test_uart_rx_lsr.sv
module test_uart_rx_lsr;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic       rx_line = 1'b1;
    logic       host_rd_data = 1'b0;
    logic       host_rd_lsr = 1'b0;
    logic       lsi_en = 1'b0;
    logic [5:0] tx_level = '0;
    logic       tx_shift_busy = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] lsr;
    logic       lsi_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    uart_rx_lsr i_uart_rx_lsr (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_line(rx_line),
        .host_rd_data(host_rd_data), .host_rd_lsr(host_rd_lsr),
        .lsi_en(lsi_en), .tx_level(tx_level), .tx_shift_busy(tx_shift_busy),
        .rd_data(rd_data), .lsr(lsr), .lsi_irq(lsi_irq)
    );

    // Transmit flag table: {exp lsr[6], exp lsr[5], busy, level}
    localparam logic [8:0] TX_TAB [0:5] = '{
        {2'b11, 1'b0, 6'd0},
        {2'b01, 1'b1, 6'd0},
        {2'b00, 1'b0, 6'd1},
        {2'b00, 1'b1, 6'd1},
        {2'b00, 1'b0, 6'd32},
        {2'b11, 1'b0, 6'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic pe, input logic fe, input logic bk);
        rx_done = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
        @(negedge clk);
        rx_done = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic take();
        host_rd_data = 1'b1;
        @(negedge clk);
        host_rd_data = 1'b0;
    endtask

    task automatic read_status();
        host_rd_lsr = 1'b1;
        @(negedge clk);
        host_rd_lsr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 reset lsr", lsr, 8'h60);
        check("R12 reset irq", lsi_irq, 0);
        check("R1 reset rd_data", rd_data, 8'h00);

        // R6 R7: transmit flag table
        foreach (TX_TAB[i]) begin
            tx_level = TX_TAB[i][5:0];
            tx_shift_busy = TX_TAB[i][6];
            #1;
            check("R6 R7 tx flags", lsr[6:5], TX_TAB[i][8:7]);
        end
        tx_level = '0; tx_shift_busy = 1'b0;
        lsi_en = 1'b1;
        @(negedge clk);

        // R1 R4: clean character
        put(8'hA5, 0, 0, 0);
        check("R1 ready", lsr[0], 1);
        check("R1 head data", rd_data, 8'hA5);
        check("R4 clean tags", lsr[4:2], 3'b000);

        // R4 R8 R9: tagged character behind a clean head
        put(8'h3C, 1, 0, 0);
        check("R4 tail tag hidden", lsr[4:2], 3'b000);
        check("R8 global error", lsr[7], 1);
        check("R9 no irq for hidden tag", lsi_irq, 0);
        take();
        check("R4 parity at head", lsr[4:2], 3'b001);
        check("R9 irq for head tag", lsi_irq, 1);
        put(8'h77, 0, 1, 0);
        take();
        check("R4 framing at head", lsr[4:2], 3'b010);
        take();
        check("R8 error cleared", lsr[7], 0);
        check("R1 empty", lsr[0], 0);

        // R13 R2 R10 R3: fill, overrun, clear, push on full with pop
        for (int i = 0; i < 32; i++) put(8'(i), 0, 0, 0);
        check("R13 full ready", lsr[0], 1);
        put(8'hEE, 0, 0, 0);
        check("R2 overrun set", lsr[1], 1);
        check("R9 irq on overrun", lsi_irq, 1);
        host_rd_lsr = 1'b1;
        put(8'hEF, 0, 0, 0);
        host_rd_lsr = 1'b0;
        check("R10 new overrun wins", lsr[1], 1);
        read_status();
        check("R10 read clears overrun", lsr[1], 0);
        host_rd_data = 1'b1;
        put(8'h99, 0, 0, 0);
        host_rd_data = 1'b0;
        check("R3 no overrun on push with pop", lsr[1], 0);
        bad = 0;
        for (int i = 1; i < 32; i++) begin
            if (rd_data !== 8'(i)) bad++;
            take();
        end
        check("R2 R13 order and contents", bad, 0);
        check("R3 pushed on full with pop", rd_data, 8'h99);
        take();
        check("R1 drained", lsr[0], 0);

        // R5: break collapsing
        rx_line = 1'b0;
        put(8'h55, 0, 1, 1);
        check("R5 break data", rd_data, 8'h00);
        check("R5 break tags", lsr[4:2], 3'b100);
        check("R8 break counted", lsr[7], 1);
        put(8'h00, 0, 1, 1);
        put(8'h12, 0, 0, 0);
        take();
        check("R5 later frames ignored", lsr[0], 0);
        rx_line = 1'b1;
        @(negedge clk);
        put(8'h42, 0, 0, 0);
        check("R5 accepted after idle", rd_data, 8'h42);
        take();

        // R11: single holding slot
        fifo_mode = 1'b0;
        @(negedge clk);
        put(8'h11, 0, 0, 0);
        put(8'h22, 0, 0, 0);
        check("R11 overrun at one", lsr[1], 1);
        check("R11 first kept", rd_data, 8'h11);
        take();
        check("R11 empty after read", lsr[0], 0);
        read_status();

        // R9: disabled interrupt
        lsi_en = 1'b0;
        put(8'h01, 0, 0, 0);
        put(8'h02, 0, 0, 0);
        check("R9 irq masked", lsi_irq, 0);
        check("R9 overrun still flagged", lsr[1], 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule